// File: doc/BRIEF.md
# Selectable Video Frame Effect Unit

This block sits in a streaming video path and rewrites each pixel of a frame with one of several visual effects. Pixels arrive one 32-bit word at a time under a valid/ready handshake, the first pixel of a frame carrying a start-of-frame flag. The block tracks the column and row of every pixel itself, so the upstream source sends only pixels and the frame marker. The default frame is 640 columns by 480 lines. Both dimensions are parameters.

A 2-bit effect selector chooses the treatment for a whole frame. The selector is captured only together with the start-of-frame pixel, which keeps one frame from being processed under two different settings. The selections are:

- plain pass-through;
- a grid of black dots;
- colour inversion;
- a split screen whose four quadrants each receive a different effect: dots, inversion, darkening, or pseudo-random noise.

The output stream keeps the input framing and arrives two register stages later. A stalled consumer freezes the whole pipeline, including the position counters and the noise generator.

Top module: `vfx_frame_effect`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid` is 0 until a pixel has passed through the pipeline, and `in_ready` is 1 once reset is released with the pipeline empty.
- R2: Selector value 0 (pass-through) outputs every pixel bit-for-bit unchanged.
- R3: Selector value 1 (dot grid) clears bits [23:0] of a pixel whose column and row are both multiples of 4. Bits [31:24] of that pixel are kept. All other pixels pass unchanged.
- R4: Selector value 2 (invert) outputs bits [23:0] bitwise complemented and bits [31:24] unchanged.
- R5: Selector value 3 (split screen) sets the quadrant by `col < W/2` and `row < H/2`. Top-left gets the R3 dot grid using absolute column and row. Top-right gets R4 inversion. Bottom-left shifts each of the bytes [23:16], [15:8] and [7:0] right by one, keeping bits [31:24]. Bottom-right gets the R6 noise.
- R6: Noise comes from a 16-bit shift register: next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It holds 16'hACE1 for the start-of-frame pixel and advances once per accepted pixel. A noisy pixel has bits [1:0] XORed with s[1:0], bits [9:8] with s[3:2] and bits [17:16] with s[5:4]. Every other bit is unchanged.
- R7: The selector is captured only with an accepted start-of-frame pixel. Changes to it during a frame have no effect until the next start of frame.
- R8: Column runs 0 to W-1 and then wraps, incrementing the row, which wraps after H-1. A start-of-frame pixel is always at column 0, row 0, even when the previous frame was cut short.
- R9: A pixel presented before clock edge k with `out_ready` high is not yet visible after edge k. It appears on `out_pixel` with `out_valid` after edge k+1, and `out_sof` repeats its start-of-frame flag.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_pixel`/`out_sof` hold. No pixel is lost or duplicated. Column, row and noise state advance only on accepted pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Effect selector, captured with the start-of-frame pixel |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_pixel | input | 32 | Input pixel, colour in bits [23:0] |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_pixel | output | 32 | Processed pixel |

## Verification
The assertions assume two things about the inputs. First, `out_ready` and the input handshake signals are known after reset. Second, a frame begins with an asserted `in_sof`; pixels sent before any start of frame are treated as continuing from column 0, row 0 under pass-through.

The stimulus always opens a frame with a start-of-frame pixel and drives inputs only between clock edges. It shrinks the frame to 16 by 8 through the parameters so that several complete frames fit in a short run. It also cuts one frame short on purpose and then sends a fresh start of frame, so that the position reset is exercised under legal input.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

    localparam int PIX_W      = 32;
    localparam int CHAN_W     = 8;
    localparam int N_CHAN     = 3;
    localparam int COLOUR_W   = CHAN_W * N_CHAN;
    localparam int POS_W      = 16;
    localparam int LFSR_W     = 16;
    localparam int NOISE_BITS = 2;
    localparam int NOISE_USE  = NOISE_BITS * N_CHAN;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_DOTS   = 2'd1,
        MODE_INVERT = 2'd2,
        MODE_QUAD   = 2'd3
    } vfx_mode_e;

    typedef enum logic [2:0] {
        FX_NONE  = 3'd0,
        FX_BLACK = 3'd1,
        FX_INV   = 3'd2,
        FX_DARK  = 3'd3,
        FX_NOISE = 3'd4
    } vfx_fx_e;

    typedef struct packed {
        logic                 sof;
        logic [PIX_W-1:0]     pix;
        vfx_fx_e              fx;
        logic [NOISE_USE-1:0] noise;
    } vfx_stage_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [PIX_W-1:0] px_black(input logic [PIX_W-1:0] p);
        logic [PIX_W-1:0] r;
        r = p;
        r[COLOUR_W-1:0] = '0;
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] px_invert(input logic [PIX_W-1:0] p);
        logic [PIX_W-1:0] r;
        r = p;
        r[COLOUR_W-1:0] = ~p[COLOUR_W-1:0];
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] px_darken(input logic [PIX_W-1:0] p);
        logic [PIX_W-1:0] r;
        r = p;
        for (int c = 0; c < N_CHAN; c++) begin
            r[c*CHAN_W +: CHAN_W] = p[c*CHAN_W +: CHAN_W] >> 1;
        end
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] px_noise(input logic [PIX_W-1:0] p,
                                                   input logic [NOISE_USE-1:0] n);
        logic [PIX_W-1:0] r;
        r = p;
        for (int c = 0; c < N_CHAN; c++) begin
            r[c*CHAN_W +: NOISE_BITS] = p[c*CHAN_W +: NOISE_BITS] ^ n[c*NOISE_BITS +: NOISE_BITS];
        end
        return r;
    endfunction

endpackage

// File: rtl/vfx_pos_track.sv
module vfx_pos_track
    import vfx_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             sof_i,
    output logic [POS_W-1:0] col_o,
    output logic [POS_W-1:0] row_o
);
    localparam logic [POS_W-1:0] LAST_COL = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] LAST_ROW = POS_W'(FRAME_H - 1);

    logic [POS_W-1:0] col_q, row_q;

    // position of the pixel now on the input
    assign col_o = sof_i ? '0 : col_q;
    assign row_o = sof_i ? '0 : row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (step_i) begin
            if (col_o == LAST_COL) begin
                col_q <= '0;
                row_q <= (row_o == LAST_ROW) ? '0 : row_o + 1'b1;
            end else begin
                col_q <= col_o + 1'b1;
                row_q <= row_o;
            end
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (col_q <= LAST_COL) && (row_q <= LAST_ROW));  // R8

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step_i && col_o == LAST_COL && row_o != LAST_ROW) |=>
            (col_q == '0) && (row_q == $past(row_o) + 1'b1));  // R8

endmodule

// File: rtl/vfx_lfsr.sv
module vfx_lfsr
    import vfx_pkg::*;
#(
    parameter int OUT_W = NOISE_USE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             restart_i,
    output logic [OUT_W-1:0] value_o
);
    logic [LFSR_W-1:0] state_q, cur;

    assign cur     = restart_i ? LFSR_SEED : state_q;
    assign value_o = cur[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)         state_q <= LFSR_SEED;
        else if (step_i) state_q <= lfsr_next(cur);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);  // R6

    AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(state_q));  // R10

endmodule

// File: rtl/vfx_fx_select.sv
module vfx_fx_select
    import vfx_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480
) (
    input  vfx_mode_e        mode_i,
    input  logic [POS_W-1:0] col_i,
    input  logic [POS_W-1:0] row_i,
    output vfx_fx_e          fx_o
);
    localparam logic [POS_W-1:0] HALF_W = POS_W'(FRAME_W / 2);
    localparam logic [POS_W-1:0] HALF_H = POS_W'(FRAME_H / 2);

    logic on_grid, left, top;
    vfx_fx_e dots_fx;

    assign on_grid = (col_i[1:0] == 2'b00) && (row_i[1:0] == 2'b00);
    assign left    = col_i < HALF_W;
    assign top     = row_i < HALF_H;
    assign dots_fx = on_grid ? FX_BLACK : FX_NONE;

    always_comb begin
        unique case (mode_i)
            MODE_PASS:   fx_o = FX_NONE;
            MODE_DOTS:   fx_o = dots_fx;
            MODE_INVERT: fx_o = FX_INV;
            default: begin
                if (top) fx_o = left ? dots_fx : FX_INV;
                else     fx_o = left ? FX_DARK : FX_NOISE;
            end
        endcase
    end

endmodule

// File: rtl/vfx_apply.sv
module vfx_apply
    import vfx_pkg::*;
(
    input  vfx_stage_t       stage_i,
    output logic [PIX_W-1:0] pix_o
);
    always_comb begin
        unique case (stage_i.fx)
            FX_BLACK: pix_o = px_black(stage_i.pix);
            FX_INV:   pix_o = px_invert(stage_i.pix);
            FX_DARK:  pix_o = px_darken(stage_i.pix);
            FX_NOISE: pix_o = px_noise(stage_i.pix, stage_i.noise);
            default:  pix_o = stage_i.pix;
        endcase
    end
endmodule

// File: rtl/vfx_frame_effect.sv
module vfx_frame_effect
    import vfx_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pixel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pixel
);
    logic advance, take;
    vfx_mode_e mode_q, mode_now;
    logic [POS_W-1:0] col, row;
    logic [NOISE_USE-1:0] noise;
    vfx_fx_e fx;
    vfx_stage_t s1_d, s1_q;
    logic s1_valid;
    logic [PIX_W-1:0] fx_pix;

    // whole pipeline moves together unless the output is held
    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;
    assign take     = in_valid && advance;

    assign mode_now = in_sof ? vfx_mode_e'(mode_sel) : mode_q;

    always_ff @(posedge clk) begin
        if (rst)                  mode_q <= MODE_PASS;
        else if (take && in_sof)  mode_q <= vfx_mode_e'(mode_sel);
    end

    vfx_pos_track #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_pos (
        .clk(clk), .rst(rst), .step_i(take), .sof_i(in_sof),
        .col_o(col), .row_o(row)
    );

    vfx_lfsr #(.OUT_W(NOISE_USE)) u_noise (
        .clk(clk), .rst(rst), .step_i(take), .restart_i(in_sof),
        .value_o(noise)
    );

    vfx_fx_select #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_sel (
        .mode_i(mode_now), .col_i(col), .row_i(row), .fx_o(fx)
    );

    always_comb begin
        s1_d.sof   = in_sof;
        s1_d.pix   = in_pixel;
        s1_d.fx    = fx;
        s1_d.noise = noise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else if (advance) begin
            s1_valid <= in_valid;
            s1_q     <= s1_d;
        end
    end

    vfx_apply u_apply (.stage_i(s1_q), .pix_o(fx_pix));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_pixel <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            out_sof   <= s1_q.sof;
            out_pixel <= fx_pix;
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_pixel) && $stable(out_sof));  // R10

    AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));  // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(take && in_sof) |=> $stable(mode_q));  // R7

endmodule

// File: tb/vfx_frame_effect_tb.sv
`timescale 1ns/1ps
module vfx_frame_effect_tb;

    localparam int TW = 16;
    localparam int TH = 8;
    localparam int NPIX = TW * TH;
    localparam logic [15:0] SEED = 16'hACE1;

    // {mode_at_sof[29:28], mode_mid[27:26], stall[25], restart[24], len[23:8], seed[7:0]}
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 1'b0, 16'(NPIX), 8'd11},  // R2
        {2'd1, 2'd1, 1'b0, 1'b0, 16'(NPIX), 8'd22},  // R3
        {2'd2, 2'd2, 1'b0, 1'b0, 16'(NPIX), 8'd33},  // R4
        {2'd3, 2'd3, 1'b0, 1'b0, 16'(NPIX), 8'd44},  // R5 R6
        {2'd3, 2'd0, 1'b0, 1'b0, 16'(NPIX), 8'd55},  // R7
        {2'd1, 2'd1, 1'b0, 1'b0, 16'd37,    8'd66},  // cut-short frame
        {2'd3, 2'd3, 1'b0, 1'b1, 16'(NPIX), 8'd77},  // R8
        {2'd3, 2'd3, 1'b1, 1'b0, 16'(NPIX), 8'd99}   // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic        in_valid, in_ready, in_sof;
    logic [31:0] in_pixel;
    logic        out_valid, out_ready, out_sof;
    logic [31:0] out_pixel;

    always #10 clk = ~clk;

    vfx_frame_effect #(.FRAME_W(TW), .FRAME_H(TH)) u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pixel(in_pixel),
        .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_pixel(out_pixel)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    int          mx, my;
    logic [1:0]  mmode;
    logic [15:0] ml;
    int          cyc = 0;
    bit          stall_on = 0;

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bench_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int quad_fx(input int x, input int y, input logic [1:0] md);
        if (md == 2'd0) return 0;
        if (md == 2'd1) return 1;
        if (md == 2'd2) return 2;
        if (y < TH/2) return (x < TW/2) ? 1 : 2;
        return (x < TW/2) ? 3 : 4;
    endfunction

    function automatic logic [31:0] model_px(input logic [31:0] p, input int x, input int y,
                                             input logic [1:0] md, input logic [15:0] l);
        logic [31:0] r;
        r = p;
        case (quad_fx(x, y, md))
            1: if ((x % 4 == 0) && (y % 4 == 0)) r[23:0] = 24'h0;
            2: r[23:0] = ~p[23:0];
            3: r[23:0] = {1'b0, p[23:17], 1'b0, p[15:9], 1'b0, p[7:1]};
            4: r[23:0] = p[23:0] ^ {6'b0, l[5:4], 6'b0, l[3:2], 6'b0, l[1:0]};
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] gen_pix(input logic [7:0] s, input int i);
        return {8'(s + i), 8'(i * 7), 8'(i * 13 + s), 8'((i * 29) ^ s)};
    endfunction

    task automatic set_ready();
        out_ready = !(stall_on && (cyc % 3 == 1));
    endtask

    task automatic send_pix(input logic [31:0] pix, input logic sof,
                            input logic [1:0] md, input string tag);
        string t;
        @(negedge clk); cyc++;
        in_valid = 1'b1; in_pixel = pix; in_sof = sof; mode_sel = md;
        set_ready();
        #2;
        while (!in_ready) begin
            @(negedge clk); cyc++;
            set_ready();
            #2;
        end
        if (sof) begin mx = 0; my = 0; mmode = md; ml = SEED; end
        t = tag;
        if (t == "") begin
            case (mmode)
                2'd0: t = "R2";
                2'd1: t = "R3";
                2'd2: t = "R4";
                default: t = (quad_fx(mx, my, mmode) == 4) ? "R6" : "R5";
            endcase
        end
        exp_q.push_back({sof, model_px(pix, mx, my, mmode, ml)});
        tag_q.push_back(t);
        ml = bench_lfsr(ml);
        mx++;
        if (mx == TW) begin mx = 0; my++; if (my == TH) my = 0; end
    endtask

    task automatic go_idle();
        @(negedge clk); cyc++;
        in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
    endtask

    // scoreboard: sample between edges
    initial begin
        forever begin
            @(negedge clk); #5;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected output", {out_sof, out_pixel}, 33'h0);
                    if ({out_sof, out_pixel} == 33'h0) begin n_fail++; $display("FAIL R10 extra output actual=0 expected=none"); end
                end else begin
                    check(tag_q.pop_front(), {out_sof, out_pixel}, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_pixel = '0;
        mode_sel = 2'd0; out_ready = 1'b1;
        mx = 0; my = 0; mmode = 2'd0; ml = SEED;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {32'h0, out_valid}, 33'h0);
        rst = 1'b0;
        @(negedge clk); #3;
        check("R1 out_valid after reset", {32'h0, out_valid}, 33'h0);
        check("R1 in_ready after reset", {32'h0, in_ready}, 33'h1);

        // R9 latency: one start-of-frame pixel, inverted
        send_pix(32'hA5_123456, 1'b1, 2'd2, "R9");
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; #3;
        check("R9 not visible after first edge", {32'h0, out_valid}, 33'h0);
        @(negedge clk); #3;
        check("R9 visible after second edge", {out_sof, out_valid, 31'h0}, {1'b1, 1'b1, 31'h0});
        check("R9 pixel value", {1'b0, out_pixel}, {1'b0, 32'hA5_EDCBA9});

        // R10 directed stall
        send_pix(32'h3C_0F0F0F, 1'b1, 2'd0, "R10");
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b0;
        @(negedge clk); #3;
        check("R10 valid while held", {32'h0, out_valid}, 33'h1);
        check("R10 in_ready low while held", {32'h0, in_ready}, 33'h0);
        held = out_pixel;
        @(negedge clk); #3;
        check("R10 pixel held", {1'b0, out_pixel}, {1'b0, held});
        @(negedge clk); out_ready = 1'b1;
        repeat (3) @(negedge clk);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m0, m1;
            int len;
            string tag;
            m0 = VEC[v][29:28]; m1 = VEC[v][27:26];
            stall_on = VEC[v][25];
            len = int'(VEC[v][23:8]);
            tag = "";
            if (m0 != m1) tag = "R7";
            if (VEC[v][24]) tag = "R8";
            if (VEC[v][25]) tag = "R10";
            for (int i = 0; i < len; i++) begin
                send_pix(gen_pix(VEC[v][7:0], i), i == 0, (i < len / 2) ? m0 : m1, tag);
            end
        end
        stall_on = 0;
        go_idle();
        repeat (10) @(negedge clk);
        check("R10 all pixels delivered", 33'(exp_q.size()), 33'h0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule